// File: doc/BRIEF.md
# Multiprocessor UART Receiver with Receive FIFO

This block turns a serial line into bytes. Each frame is a low start bit, eight data bits sent least significant bit first, an optional ninth bit, and a stop bit. The line is sampled at sixteen times the bit rate, using a tick from a free divider (`CLK_DIV` clocks per tick). The ninth bit is present when either the extra-bit mode or parity is switched on. With parity on, the ninth bit is only a parity bit. With parity off and the extra-bit mode on, the ninth bit marks a frame as an address (1) or as data (0).

Accepted frames go into a three-entry FIFO. Each entry holds the byte and one extra bit. With the extra-bit mode on and parity off, that bit is the received ninth bit. In every other case it is the stop bit. The oldest byte and its extra bit are always shown at the outputs, and a read pulse removes that byte.

A ready flag is set whenever a byte is stored. Software can clear it only after the FIFO is empty. In multiprocessor mode, a frame whose stored extra bit is 0 is dropped without a trace, so only address frames raise the ready flag. Parity, framing and overrun errors each set a sticky flag, and one clear pulse resets all three.

Top module: `mp_uart_rx`

## Requirements
- R1: Frames carry 8 data bits least significant bit first, and `rd_data` shows the oldest stored byte. When `xbit_en` or `par_en` is 1, a ninth bit follows the data bits before the stop bit.
- R2: With `xbit_en`=1 and `par_en`=0, `rd_extra` shows the ninth bit of the oldest entry.
- R3: With `xbit_en`=0, or with `par_en`=1, `rd_extra` shows the stop bit of the oldest entry.
- R4: With `par_en`=1, the ninth bit is compared against the type selected by `par_sel`: 00 odd (data plus parity has an odd count of ones), 01 even, 10 always 1, 11 always 0. A mismatch sets `par_err`, which stays set until an `err_clr` pulse.
- R5: With `mp_en`=1, a frame whose extra bit (as defined in R2/R3) is 0 is not stored and does not set `rdy`. A frame whose extra bit is 1 is stored and sets `rdy`.
- R6: `rdy` is 0 after reset and is set when a byte is stored. A `rdy_clr` pulse clears it only while the FIFO is empty; otherwise `rdy` stays 1.
- R7: A `rd_pop` pulse removes the oldest byte. Bytes leave in arrival order, and up to 3 bytes are held.
- R8: A frame that finishes while the FIFO holds 3 bytes is dropped and sets `ovr_err`, which stays set until `err_clr`.
- R9: A low pulse that has returned high by the middle of the start bit is ignored. Frames that follow it are received normally.
- R10: A stop bit read as 0 sets `frm_err` (sticky until `err_clr`), and the byte is still stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxd | input | 1 | Serial receive line, idle high |
| xbit_en | input | 1 | Ninth bit carries an address/data marker |
| par_en | input | 1 | Ninth bit carries parity |
| par_sel | input | 2 | Parity type: 00 odd, 01 even, 10 one, 11 zero |
| mp_en | input | 1 | Multiprocessor mode: keep only frames with extra bit 1 |
| rdy_clr | input | 1 | Request to clear the ready flag |
| rd_pop | input | 1 | Remove the oldest byte |
| err_clr | input | 1 | Clear all error flags |
| rdy | output | 1 | Ready flag |
| rd_data | output | 8 | Oldest stored byte |
| rd_extra | output | 1 | Extra bit of the oldest stored byte |
| par_err | output | 1 | Sticky parity error |
| frm_err | output | 1 | Sticky framing error |
| ovr_err | output | 1 | Sticky overrun |

## Verification
A frame's results (`rdy`, the FIFO head, `par_err`, `frm_err`, `ovr_err`) appear one clock after the middle of the stop bit. The middle of the stop bit falls 8 ticks, plus up to one tick of divider phase and two synchronizer clocks, after the stop bit begins. The bench therefore holds the stop bit for a full bit time, waits four more clocks, and samples on falling clock edges. Software pulses (`rd_pop`, `rdy_clr`, `err_clr`) last one rising edge and take effect on that edge, so the bench checks their result at the next falling edge. No check is made while a frame is still being received.

// File: rtl/mp_uart_rx.sv
module mp_uart_rx #(
  parameter int CLK_DIV = 16,
  parameter int DEPTH   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  input  logic       xbit_en,
  input  logic       par_en,
  input  logic [1:0] par_sel,
  input  logic       mp_en,
  input  logic       rdy_clr,
  input  logic       rd_pop,
  input  logic       err_clr,
  output logic       rdy,
  output logic [7:0] rd_data,
  output logic       rd_extra,
  output logic       par_err,
  output logic       frm_err,
  output logic       ovr_err
);
  localparam int PW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_NINTH, S_STOP} st_t;

  st_t           st;
  logic          rx_m, rx_s, rx_d;
  logic [PW-1:0] pre;
  logic [3:0]    os;
  logic [2:0]    bidx;
  logic [7:0]    shreg;
  logic          ninth;
  logic [8:0]    mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;

  wire tick      = (st != S_IDLE) && (pre == PW'(CLK_DIV - 1));
  wire [3:0] lim = (st == S_START) ? 4'd7 : 4'd15;
  wire sample    = tick && (os == lim);
  wire fall      = rx_d & ~rx_s;
  wire use_ninth = xbit_en | par_en;

  wire done     = sample && (st == S_STOP);
  wire wbit     = (xbit_en && !par_en) ? ninth : rx_s;
  logic par_exp;
  always_comb begin
    case (par_sel)
      2'b00:   par_exp = ~^shreg;
      2'b01:   par_exp = ^shreg;
      2'b10:   par_exp = 1'b1;
      default: par_exp = 1'b0;
    endcase
  end
  wire par_bad  = done && par_en && (ninth != par_exp);
  wire keep     = !(mp_en && !wbit);
  wire full     = (count == CW'(DEPTH));
  wire push     = done && keep && !full;
  wire overrun  = done && keep && full;
  wire do_pop   = rd_pop && (count != '0);

  assign rd_data  = mem[rptr][7:0];
  assign rd_extra = mem[rptr][8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
      rx_d <= 1'b1;
    end else begin
      rx_m <= rxd;
      rx_s <= rx_m;
      rx_d <= rx_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      pre   <= '0;
      os    <= '0;
      bidx  <= '0;
      shreg <= '0;
      ninth <= 1'b0;
    end else begin
      if (st == S_IDLE || tick) pre <= '0;
      else                      pre <= pre + 1'b1;
      if (st == S_IDLE) begin
        os <= '0;
        if (fall) st <= S_START;
      end else if (tick) begin
        if (os == lim) begin
          os <= '0;
          case (st)
            S_START: begin
              bidx <= '0;
              st   <= rx_s ? S_IDLE : S_DATA;
            end
            S_DATA: begin
              shreg <= {rx_s, shreg[7:1]};
              bidx  <= bidx + 1'b1;
              if (bidx == 3'd7) st <= use_ninth ? S_NINTH : S_STOP;
            end
            S_NINTH: begin
              ninth <= rx_s;
              st    <= S_STOP;
            end
            default: st <= S_IDLE;
          endcase
        end else begin
          os <= os + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) begin
        mem[wptr] <= {wbit, shreg};
        wptr      <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      end
      if (do_pop) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      count <= count + CW'(push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy     <= 1'b0;
      par_err <= 1'b0;
      frm_err <= 1'b0;
      ovr_err <= 1'b0;
    end else begin
      if (push)                           rdy <= 1'b1;
      else if (rdy_clr && count == '0)    rdy <= 1'b0;
      if (par_bad)                        par_err <= 1'b1;
      else if (err_clr)                   par_err <= 1'b0;
      if (done && !rx_s)                  frm_err <= 1'b1;
      else if (err_clr)                   frm_err <= 1'b0;
      if (overrun)                        ovr_err <= 1'b1;
      else if (err_clr)                   ovr_err <= 1'b0;
    end
  end

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_pop_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && count != '0 && !push) |=> (count == $past(count) - CW'(1)));
  assert_rdy_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && rdy_clr && count != '0) |=> rdy);
  assert_rdy_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy |-> (count == '0));
  assert_perr_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err && !err_clr) |=> par_err);
  assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_err && !err_clr) |=> ovr_err);
  assert_ferr_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_err && !err_clr) |=> frm_err);
  assert_mp_filter_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mp_en && $stable(mp_en) && count == $past(count) + CW'(1)) |-> mem[$past(wptr)][8]);
endmodule

// File: tb/test_mp_uart_rx.sv
module test_mp_uart_rx;
  localparam int CLK_DIV = 4;
  localparam int BIT     = CLK_DIV * 16;

  logic clk = 1'b0, rst_n = 1'b0, rxd = 1'b1;
  logic xbit_en = 0, par_en = 0, mp_en = 0, rdy_clr = 0, rd_pop = 0, err_clr = 0;
  logic [1:0] par_sel = 2'b00;
  logic rdy, rd_extra, par_err, frm_err, ovr_err;
  logic [7:0] rd_data;
  int tests = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mp_uart_rx #(.CLK_DIV(CLK_DIV), .DEPTH(3)) i_mp_uart_rx (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .xbit_en(xbit_en), .par_en(par_en),
    .par_sel(par_sel), .mp_en(mp_en), .rdy_clr(rdy_clr), .rd_pop(rd_pop),
    .err_clr(err_clr), .rdy(rdy), .rd_data(rd_data), .rd_extra(rd_extra),
    .par_err(par_err), .frm_err(frm_err), .ovr_err(ovr_err));

  // {xbit_en, par_en, par_sel[1:0], mp_en, data[7:0], ninth, stop, exp_push, exp_extra, exp_perr, exp_ferr}
  localparam logic [18:0] VEC [12] = '{
    {1'b0,1'b0,2'b00,1'b0,8'hA5,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0},
    {1'b1,1'b0,2'b00,1'b0,8'h3C,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0},
    {1'b1,1'b0,2'b00,1'b0,8'h3C,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0},
    {1'b0,1'b1,2'b00,1'b0,8'h01,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0},
    {1'b0,1'b1,2'b00,1'b0,8'h01,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0},
    {1'b0,1'b1,2'b01,1'b0,8'h03,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0},
    {1'b0,1'b1,2'b10,1'b0,8'h5A,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0},
    {1'b0,1'b1,2'b11,1'b0,8'h5A,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0},
    {1'b1,1'b0,2'b00,1'b1,8'h42,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0},
    {1'b1,1'b0,2'b00,1'b1,8'h42,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0},
    {1'b0,1'b0,2'b00,1'b0,8'h77,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1},
    {1'b0,1'b0,2'b00,1'b1,8'h77,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bit_out(input logic v);
    rxd = v;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic has9, input logic b9, input logic stop);
    bit_out(1'b0);
    for (int i = 0; i < 8; i++) bit_out(d[i]);
    if (has9) bit_out(b9);
    bit_out(stop);
    rxd = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1;
    @(negedge clk);
    s = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 reset rdy", rdy, 0);
    chk("R4 reset par_err", par_err, 0);
    chk("R8 reset ovr_err", ovr_err, 0);
    chk("R10 reset frm_err", frm_err, 0);

    for (int k = 0; k < 12; k++) begin
      logic [18:0] v;
      v = VEC[k];
      xbit_en = v[18]; par_en = v[17]; par_sel = v[16:15]; mp_en = v[14];
      pulse(err_clr);
      send(v[13:6], v[18] | v[17], v[5], v[4]);
      chk(v[14] ? "R5 rdy after frame" : "R1 rdy after frame", rdy, v[3]);
      if (v[3]) begin
        chk("R1 data", rd_data, v[13:6]);
        chk((v[18] && !v[17]) ? "R2 extra" : "R3 extra", rd_extra, v[2]);
        pulse(rd_pop);
        pulse(rdy_clr);
        chk("R6 clear when empty", rdy, 0);
      end
      chk("R4 parity flag", par_err, v[1]);
      chk("R10 framing flag", frm_err, v[0]);
    end

    xbit_en = 0; par_en = 1; par_sel = 2'b01; mp_en = 0;
    pulse(err_clr);
    send(8'h01, 1'b1, 1'b0, 1'b1);
    send(8'h03, 1'b1, 1'b0, 1'b1);
    chk("R4 parity sticky", par_err, 1);
    pulse(err_clr);
    chk("R4 parity cleared", par_err, 0);
    repeat (2) pulse(rd_pop);
    pulse(rdy_clr);

    par_en = 0;
    send(8'h11, 1'b0, 1'b0, 1'b1);
    send(8'h22, 1'b0, 1'b0, 1'b1);
    send(8'h33, 1'b0, 1'b0, 1'b1);
    chk("R8 no overrun at 3", ovr_err, 0);
    send(8'h44, 1'b0, 1'b0, 1'b1);
    chk("R8 overrun flag", ovr_err, 1);
    pulse(rdy_clr);
    chk("R6 clear refused while full", rdy, 1);
    chk("R7 oldest first", rd_data, 8'h11);
    pulse(rd_pop);
    pulse(rdy_clr);
    chk("R6 clear refused with 2 left", rdy, 1);
    chk("R7 second", rd_data, 8'h22);
    pulse(rd_pop);
    chk("R7 third", rd_data, 8'h33);
    pulse(rd_pop);
    pulse(rdy_clr);
    chk("R6 clear after drain", rdy, 0);
    pulse(err_clr);
    chk("R8 overrun cleared", ovr_err, 0);

    rxd = 1'b0;
    repeat (3 * CLK_DIV) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * BIT) @(negedge clk);
    chk("R9 glitch ignored", rdy, 0);
    send(8'h5E, 1'b0, 1'b0, 1'b1);
    chk("R9 frame after glitch", rdy, 1);
    chk("R9 data after glitch", rd_data, 8'h5E);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule